// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address for each beat of a short burst. It is used in front of a synchronous memory array. A load captures a full external address. The lowest address bits are the starting beat position. The upper bits select an aligned block of four words. Each following advance cycle steps an internal beat counter. The block then presents the next address of the burst. Only the low bits move, and they wrap inside the block.

Two beat orders are available, chosen at load time by one select input:
- **Wrap-around linear:** the low bits count up modulo four from the start.
- **Interleaved:** the low bits are the start position XOR the beat count.

A clock enable freezes the whole block. A qualifier from the chip-select logic decides whether a load request is accepted. The current beat address is held in a register and driven every cycle.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `beat_addr` becomes 0 after that edge. The beat counter and start position clear to 0, and the order clears to linear.
- R2: An accepted load takes place at an edge with `clk_en_n`=0, `adv_ld_n`=0 and `load_ok`=1. After that edge, `beat_addr` equals `addr_in`.
- R3: A load request (`adv_ld_n`=0) with `load_ok`=0 is ignored. `beat_addr` keeps its value, and later advances continue the burst that was already in progress.
- R4: Advance cycles are edges with `clk_en_n`=0 and `adv_ld_n`=1. In linear order (`order_sel`=0 at load), after the k-th advance the two low bits of `beat_addr` equal (start + k) mod 4. Example: start 2 gives 2,3,0,1.
- R5: In interleaved order (`order_sel`=1 at load), after the k-th advance the two low bits equal start XOR (k mod 4). Example: start 1 gives 1,0,3,2.
- R6: `order_sel` is sampled only on an accepted load. Changing it during a burst does not alter the sequence.
- R7: Advancing past the fourth beat wraps to the first beat of the same block. No carry reaches the upper address bits.
- R8: When `clk_en_n` is high, `beat_addr` and all internal state hold, whatever the other inputs are.
- R9: Bits above the two low bits of `beat_addr` stay equal to those of the last accepted load throughout advances.
- R10: `beat_addr` is registered. It changes only on a clock edge, and one edge after the qualifying inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en_n | input | 1 | Active-low clock enable; high freezes the block |
| adv_ld_n | input | 1 | Low requests a load; high advances the burst |
| load_ok | input | 1 | Chip-select qualifier; a load is accepted only when high |
| order_sel | input | 1 | Beat order at load: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External start address |
| beat_addr | output | ADDR_W | Current beat word address |

## Verification
The bench uses the default build, a 19-bit address and a four-beat burst. With these values, upper-bit carry and wrap-around both show up in short runs:
- Random start addresses often land at the top of a block.
- Long advance runs pass the fourth beat many times.

Random stimulus mixes loads, rejected loads, frozen cycles and mid-burst order flips. This brings loads to within a few beats of each other, and it exercises wrap in both orders.

// File: rtl/bag_pkg.sv
package bag_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;
endpackage

// File: rtl/bag_order_map.sv
module bag_order_map #(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0]      start_pos,
  input  logic [CNT_W-1:0]      beat_idx,
  input  bag_pkg::burst_order_e order,
  output logic [CNT_W-1:0]      low_bits
);
  always_comb begin
    if (order == bag_pkg::ORD_INTERLEAVE) low_bits = start_pos ^ beat_idx;
    else                                  low_bits = start_pos + beat_idx;
  end
endmodule

// File: rtl/bag_beat_ctr.sv
module bag_beat_ctr #(
  parameter int CNT_W = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   load_en,
  input  logic                   step_en,
  input  logic [CNT_W-1:0]       start_in,
  input  bag_pkg::burst_order_e  order_in,
  output logic [CNT_W-1:0]       beat_q,
  output logic [CNT_W-1:0]       beat_nxt,
  output logic [CNT_W-1:0]       start_q,
  output bag_pkg::burst_order_e  order_q
);
  assign beat_nxt = beat_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q  <= '0;
      start_q <= '0;
      order_q <= bag_pkg::ORD_LINEAR;
    end else if (load_en) begin
      beat_q  <= '0;
      start_q <= start_in;
      order_q <= order_in;
    end else if (step_en) begin
      beat_q  <= beat_nxt;
    end
  end

  AST_BEAT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step_en && !load_en && beat_q == '1) |=> (beat_q == '0)); // R7
  AST_ORDER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (!load_en) |=> $stable(order_q)); // R6
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W    = 19,
  parameter int BURST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_en_n,
  input  logic              adv_ld_n,
  input  logic              load_ok,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] beat_addr
);
  localparam int CNT_W = $clog2(BURST_LEN);

  logic                  load_en, step_en;
  logic [CNT_W-1:0]      beat_q, beat_nxt, start_q, low_nxt;
  bag_pkg::burst_order_e order_q, order_in;

  assign load_en  = !clk_en_n && !adv_ld_n && load_ok;
  assign step_en  = !clk_en_n &&  adv_ld_n;
  assign order_in = bag_pkg::burst_order_e'(order_sel);

  bag_beat_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .step_en  (step_en),
    .start_in (addr_in[CNT_W-1:0]),
    .order_in (order_in),
    .beat_q   (beat_q),
    .beat_nxt (beat_nxt),
    .start_q  (start_q),
    .order_q  (order_q)
  );

  bag_order_map #(.CNT_W(CNT_W)) u_map (
    .start_pos (start_q),
    .beat_idx  (beat_nxt),
    .order     (order_q),
    .low_bits  (low_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst)          beat_addr <= '0;
    else if (load_en) beat_addr <= addr_in;
    else if (step_en) beat_addr <= {beat_addr[ADDR_W-1:CNT_W], low_nxt};
  end

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (beat_addr == '0)); // R1
  AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (rst)
    load_en |=> (beat_addr == $past(addr_in))); // R2
  AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!clk_en_n && !adv_ld_n && !load_ok) |=> $stable(beat_addr)); // R3
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    clk_en_n |=> ($stable(beat_addr) && $stable(beat_q) && $stable(start_q))); // R8
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    step_en |=> $stable(beat_addr[ADDR_W-1:CNT_W])); // R9
endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clk_en_n = 1'b0, adv_ld_n = 1'b1, load_ok = 1'b0, order_sel = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] beat_addr;

  int checks = 0;
  int errors = 0;

  logic [AW-3:0] m_hi;
  logic [1:0]    m_start, m_beat;
  logic          m_mode;
  logic [AW-1:0] m_out;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen u_burst_addr_gen (
    .clk(clk), .rst(rst), .clk_en_n(clk_en_n), .adv_ld_n(adv_ld_n),
    .load_ok(load_ok), .order_sel(order_sel), .addr_in(addr_in),
    .beat_addr(beat_addr)
  );

  function automatic logic [1:0] lo_of(input logic [1:0] s, input logic [1:0] k,
                                       input logic mode);
    return mode ? (s ^ k) : (s + k);
  endfunction

  task automatic model_edge();
    if (rst) begin
      m_hi = '0; m_start = '0; m_beat = '0; m_mode = 1'b0; m_out = '0;
    end else if (!clk_en_n) begin
      if (!adv_ld_n) begin
        if (load_ok) begin
          m_hi = addr_in[AW-1:2]; m_start = addr_in[1:0];
          m_beat = '0; m_mode = order_sel; m_out = addr_in;
        end
      end else begin
        m_beat = m_beat + 2'd1;
        m_out  = {m_out[AW-1:2], lo_of(m_start, m_beat, m_mode)};
      end
    end
  endtask

  task automatic check(input string req, input logic [AW-1:0] exp);
    checks++;
    if (beat_addr !== exp) begin
      errors++;
      $display("FAIL %s beat_addr=%0h expected=%0h", req, beat_addr, exp);
    end
  endtask

  task automatic cyc(input logic cen, input logic adv, input logic ok,
                     input logic sel, input logic [AW-1:0] a, input string req);
    clk_en_n = cen; adv_ld_n = adv; load_ok = ok; order_sel = sel; addr_in = a;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check(req, m_out);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int r;
    r = $urandom(32'd2024);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk); model_edge(); @(negedge clk);
    check("R1", 19'h0);
    rst = 1'b0;
    // linear from start 2: 2,3,0,1, then wrap to 2 (R4, R7, R9)
    cyc(0, 0, 1, 0, 19'h7FFFE, "R2");
    check("R2", 19'h7FFFE);
    cyc(0, 1, 0, 0, '0, "R4"); check("R4", 19'h7FFFF);
    cyc(0, 1, 0, 1, '0, "R6"); check("R6", 19'h7FFFC);
    cyc(0, 1, 0, 0, '0, "R4"); check("R9", 19'h7FFFD);
    cyc(0, 1, 0, 0, '0, "R7"); check("R7", 19'h7FFFE);
    // interleaved from start 1: 1,0,3,2
    cyc(0, 0, 1, 1, 19'h12341, "R2");
    cyc(0, 1, 0, 0, '0, "R5"); check("R5", 19'h12340);
    cyc(0, 1, 0, 0, '0, "R5"); check("R5", 19'h12343);
    // rejected load and frozen cycles
    cyc(0, 0, 0, 0, 19'h55555, "R3"); check("R3", 19'h12343);
    cyc(1, 0, 1, 0, 19'h00000, "R8"); check("R8", 19'h12343);
    cyc(1, 1, 0, 0, 19'h00000, "R8");
    cyc(0, 1, 0, 0, '0, "R3"); check("R3", 19'h12342);
    cyc(0, 1, 0, 0, '0, "R7"); check("R7", 19'h12341);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] pick;
      pick = 4'($urandom_range(0, 15));
      if (pick < 3)       cyc(0, 0, 1, 1'($urandom), AW'($urandom), "R2");
      else if (pick == 3) cyc(0, 0, 0, 1'($urandom), AW'($urandom), "R3");
      else if (pick == 4) cyc(1, 1'($urandom), 1'($urandom), 1'($urandom),
                              AW'($urandom), "R8");
      else                cyc(0, 1, 1'($urandom), 1'($urandom), AW'($urandom),
                              m_mode ? "R5" : "R4");
    end
    // reset mid-burst, checked in the cycle after (R10)
    rst = 1'b1;
    @(posedge clk); model_edge(); @(negedge clk);
    check("R1", 19'h0);
    rst = 1'b0;
    cyc(0, 1, 0, 0, '0, "R10"); check("R10", 19'h00001);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule